// File: doc/BRIEF.md
# Two-Way Translate-in-Parallel L1 Read Cache

This block is a read-only level-one cache of 8 KB for a 32-bit virtual address space with 4 KB pages. It is split into two ways of 4 KB each, with 128 sets of 32-byte lines. The set index (address bits 11:5) and the word select (bits 4:2) come only from the page-offset bits, so translation cannot change them. The set is therefore read with the untranslated address while the virtual page number is sent to an external translation buffer in the same cycle. The stored 20-bit physical tags of both ways are then compared against the physical page number that the translation buffer returns.

A client presents a word address and waits for one response that carries data, a hit flag or an error flag. A translation miss stalls the lookup until the translation buffer answers. A translation fault ends the access with an error and no refill. A physical-tag miss starts a whole-line refill from the next memory level. The line goes into an empty way if there is one, otherwise into the way marked least recently used for that set. No address-space identifier is stored and nothing has to be flushed when the process changes, because the tag check is exact on physical addresses.

The controller has three states. `ST_IDLE` accepts a request (IDLE→XLATE on `req_valid`). `ST_XLATE` holds the translation request: it returns to IDLE on a hit or a fault, and goes to FILL on a tag miss. `ST_FILL` holds the memory request and returns to IDLE when the line arrives.

Top module: `vipt_cache`

## Requirements
- R1: The set index is virtual address bits 11:5 and the word select is bits 4:2. The refill address is {physical page number, bits 11:5, five zero bits}.
- R2: One cycle after a request is accepted, `tlb_req` is high and `tlb_vpn` equals virtual address bits 31:12. Both hold steady, and no response is given, until `tlb_rsp_valid` is seen.
- R3: A lookup hits only when a valid line in the indexed set has a stored tag equal to the returned physical page number. The virtual page number plays no part in the compare.
- R4: When the translation response has `tlb_fault` high, the next cycle gives `rsp_valid` with `rsp_err`=1 and `rsp_hit`=0. No refill is issued and the cache contents stay as they were.
- R5: On a tag miss, `mem_req` is raised and held with a stable `mem_paddr` until `mem_rsp_valid`. The line is then written and the selected word is returned with `rsp_hit`=0.
- R6: The refill victim is the first empty way (way 0 before way 1). When both ways are valid, the victim is the way marked least recently used for that set.
- R7: Each hit and each fill marks the other way of that set as least recently used.
- R8: Two virtual pages that map to the same physical page hit on one stored copy. A line is never stored twice.
- R9: Reset clears every valid bit and every least-recently-used mark. After reset, `req_ready`=1 and `tlb_req`, `mem_req` and `rsp_valid` are 0.
- R10: A virtual address whose page has been remapped to a new physical page misses and refills without any invalidate.
- R11: A hit or a fault responds in the cycle after `tlb_rsp_valid`. A refill responds in the cycle after `mem_rsp_valid`. `req_ready` is high only in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Controller is idle and accepts a request |
| req_waddr | input | 30 | Virtual word address (byte address bits 31:2) |
| tlb_req | output | 1 | Translation request, held until answered |
| tlb_vpn | output | 20 | Virtual page number to translate |
| tlb_rsp_valid | input | 1 | Translation answer present |
| tlb_ppn | input | 20 | Physical page number |
| tlb_fault | input | 1 | Translation failed |
| mem_req | output | 1 | Line refill request, held until answered |
| mem_paddr | output | 32 | Physical line address of the refill |
| mem_rsp_valid | input | 1 | Refill line present |
| mem_rsp_line | input | 256 | Refill line data, word 0 in the low bits |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the arrays |
| rsp_err | output | 1 | Access aborted by a translation fault |
| rsp_data | output | 32 | Read word |

## Verification
The bench remaps one virtual page to a new physical frame. A cache that compared virtual tags would wrongly hit there and return stale data. It then reads one frame through two different virtual pages. A design that keyed lines on the virtual page would miss and refill a second copy. A sequence of hits and fills on one set checks the least-recently-used order: a wrong mark evicts the line that was just used, and the next access misses where a hit is expected. Translation stalls of several lengths, a fault that must not disturb the set, the last set of the array and a reset that must drop every valid line cover the remaining control corners.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XLATE,
        ST_FILL
    } cstate_t;
endpackage

// File: rtl/vipt_way.sv
module vipt_way #(
    parameter int IDX_W  = 7,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   vld;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vld <= '0;
        else if (wr_en) vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
    end

    // Read with the untranslated index, in the translation cycle
    assign rd_valid = vld[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_line  = line_mem[rd_idx];
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             old_way,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way
);
    localparam int SETS = 1 << IDX_W;

    // One bit per set: the way least recently used
    logic [SETS-1:0] mark;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mark <= '0;
        else if (touch_en) mark[touch_idx] <= ~touch_way;
    end

    assign old_way = mark[rd_idx];
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int OFF_W  = 5,
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-$clog2(WORD_W/8)-1:0] req_waddr,
    output logic                        tlb_req,
    output logic [ADDR_W-PAGE_W-1:0]    tlb_vpn,
    input  logic                        tlb_rsp_valid,
    input  logic [ADDR_W-PAGE_W-1:0]    tlb_ppn,
    input  logic                        tlb_fault,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_paddr,
    input  logic                        mem_rsp_valid,
    input  logic [(8<<OFF_W)-1:0]       mem_rsp_line,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic                        rsp_err,
    output logic [WORD_W-1:0]           rsp_data
);
    import vipt_pkg::*;

    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int IDX_W  = PAGE_W - OFF_W;
    localparam int TAG_W  = ADDR_W - PAGE_W;
    localparam int LINE_W = 8 << OFF_W;
    localparam int WSEL_W = OFF_W - BYTE_W;
    localparam int WAYS   = 2;

    cstate_t state, state_nx;

    logic [ADDR_W-1:BYTE_W] va_q;
    logic [TAG_W-1:0]       ppn_q;
    logic                   vict_q;

    logic [IDX_W-1:0]  idx;
    logic [WSEL_W-1:0] wsel;
    logic [WAYS-1:0]   way_vld, way_wr, hit_w;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [LINE_W-1:0] way_line [WAYS];
    logic              lru_old, hit_any, hit_way, vict_c;
    logic              look_done, fill_done, tag_miss;
    logic              touch_en, touch_way;
    logic [WORD_W-1:0] hit_word, fill_word;

    assign idx  = va_q[PAGE_W-1:OFF_W];
    assign wsel = va_q[OFF_W-1:BYTE_W];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign way_wr[w] = fill_done && (vict_q == 1'(w));
            assign hit_w[w]  = look_done && !tlb_fault && way_vld[w]
                               && (way_tag[w] == tlb_ppn);
            vipt_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
                .clk     (clk),
                .rst_n   (rst_n),
                .rd_idx  (idx),
                .rd_valid(way_vld[w]),
                .rd_tag  (way_tag[w]),
                .rd_line (way_line[w]),
                .wr_en   (way_wr[w]),
                .wr_idx  (idx),
                .wr_tag  (ppn_q),
                .wr_line (mem_rsp_line)
            );
        end
    endgenerate

    vipt_lru #(.IDX_W(IDX_W)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .old_way  (lru_old),
        .touch_en (touch_en),
        .touch_idx(idx),
        .touch_way(touch_way)
    );

    assign look_done = (state == ST_XLATE) && tlb_rsp_valid;
    assign fill_done = (state == ST_FILL) && mem_rsp_valid;
    assign hit_any   = |hit_w;
    assign hit_way   = hit_w[1];
    assign tag_miss  = look_done && !tlb_fault && !hit_any;
    assign vict_c    = !way_vld[0] ? 1'b0 : (!way_vld[1] ? 1'b1 : lru_old);
    assign touch_en  = hit_any || fill_done;
    assign touch_way = fill_done ? vict_q : hit_way;
    assign hit_word  = way_line[hit_way][wsel*WORD_W +: WORD_W];
    assign fill_word = mem_rsp_line[wsel*WORD_W +: WORD_W];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_XLATE;
            ST_XLATE: if (tlb_rsp_valid)
                          state_nx = (tlb_fault || hit_any) ? ST_IDLE : ST_FILL;
            ST_FILL:  if (mem_rsp_valid) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Request and miss context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            ppn_q  <= '0;
            vict_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) va_q <= req_waddr;
            if (tag_miss) begin
                ppn_q  <= tlb_ppn;
                vict_q <= vict_c;
            end
        end
    end

    // Registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_err   <= 1'b0;
            unique case (state)
                ST_XLATE: if (tlb_rsp_valid && (tlb_fault || hit_any)) begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= tlb_fault;
                    rsp_hit   <= !tlb_fault;
                    rsp_data  <= tlb_fault ? '0 : hit_word;
                end
                ST_FILL: if (mem_rsp_valid) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= fill_word;
                end
                default: ;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign tlb_req   = (state == ST_XLATE);
    assign tlb_vpn   = va_q[ADDR_W-1:PAGE_W];
    assign mem_req   = (state == ST_FILL);
    assign mem_paddr = {ppn_q, idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
    parameter int TAG_W = 20,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tlb_req,
    input logic [TAG_W-1:0]  tlb_vpn,
    input logic              tlb_rsp_valid,
    input logic              tlb_fault,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_paddr,
    input logic              mem_rsp_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_err,
    input logic [1:0]        hit_w
);
    p_tlb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req && !tlb_rsp_valid |=> tlb_req && $stable(tlb_vpn) && !rsp_valid);

    p_fault_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req && tlb_rsp_valid && tlb_fault |=> rsp_valid && rsp_err && !rsp_hit && !mem_req);

    p_miss_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req && tlb_rsp_valid && !tlb_fault && (hit_w == 2'b00) |=> mem_req && !rsp_valid);

    p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_paddr));

    p_fill_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rsp_valid |=> rsp_valid && !rsp_hit && !rsp_err);

    p_single_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_w));

    p_hit_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w != 2'b00) |=> rsp_valid && rsp_hit);
endmodule

bind vipt_cache vipt_cache_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tlb_req      (tlb_req),
    .tlb_vpn      (tlb_vpn),
    .tlb_rsp_valid(tlb_rsp_valid),
    .tlb_fault    (tlb_fault),
    .mem_req      (mem_req),
    .mem_paddr    (mem_paddr),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_err      (rsp_err),
    .hit_w        (hit_w)
);

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [29:0]  req_waddr = '0;
    logic         tlb_req;
    logic [19:0]  tlb_vpn;
    logic         tlb_rsp_valid = 1'b0;
    logic [19:0]  tlb_ppn = '0;
    logic         tlb_fault = 1'b0;
    logic         mem_req;
    logic [31:0]  mem_paddr;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rsp_line = '0;
    logic         rsp_valid, rsp_hit, rsp_err;
    logic [31:0]  rsp_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    vipt_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_waddr(req_waddr),
        .tlb_req(tlb_req), .tlb_vpn(tlb_vpn), .tlb_rsp_valid(tlb_rsp_valid),
        .tlb_ppn(tlb_ppn), .tlb_fault(tlb_fault),
        .mem_req(mem_req), .mem_paddr(mem_paddr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_line(mem_rsp_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [19:0] ppn;
        logic        flt;
        logic [1:0]  lat;
        logic        xhit;
        logic        xerr;
    } vec_t;

    localparam int NV = 15;
    // All but the last two use set 2 (bits 11:5 = 2)
    localparam vec_t TBL [NV] = '{
        '{32'h0001_2040, 20'h00080, 1'b0, 2'd0, 1'b0, 1'b0}, // cold miss -> way0 (R5 R6)
        '{32'h0001_2040, 20'h00080, 1'b0, 2'd2, 1'b1, 1'b0}, // hit after stall (R2 R3)
        '{32'h0005_5040, 20'h00080, 1'b0, 2'd1, 1'b1, 1'b0}, // synonym hits (R8)
        '{32'h0001_2040, 20'h000A0, 1'b0, 2'd0, 1'b0, 1'b0}, // remapped page misses -> way1 (R10 R6)
        '{32'h0003_3048, 20'h00080, 1'b0, 2'd3, 1'b1, 1'b0}, // hit way0, old=way1 (R7)
        '{32'h0001_2044, 20'h000C0, 1'b0, 2'd0, 1'b0, 1'b0}, // evicts A0 from way1 (R6)
        '{32'h0001_2040, 20'h00080, 1'b0, 2'd0, 1'b1, 1'b0}, // 80 survived (R7)
        '{32'h0001_2040, 20'h000A0, 1'b0, 2'd1, 1'b0, 1'b0}, // evicts C0 from way1 (R6 R7)
        '{32'h0001_2040, 20'h000C0, 1'b0, 2'd0, 1'b0, 1'b0}, // evicts 80 from way0 (R7)
        '{32'h0001_2040, 20'h000A0, 1'b0, 2'd0, 1'b1, 1'b0}, // A0 kept (R7)
        '{32'h0001_2040, 20'h00080, 1'b0, 2'd0, 1'b0, 1'b0}, // evicts C0 from way0 (R7)
        '{32'h0009_9040, 20'h00000, 1'b1, 2'd2, 1'b0, 1'b1}, // fault (R4)
        '{32'h0001_2040, 20'h00080, 1'b0, 2'd0, 1'b1, 1'b0}, // set untouched by fault (R4)
        '{32'h0000_0FE0, 20'h00123, 1'b0, 2'd0, 1'b0, 1'b0}, // last set (R1)
        '{32'h0000_0FFC, 20'h00123, 1'b0, 2'd1, 1'b1, 1'b0}  // last word of last set (R1)
    };

    function automatic logic [31:0] mword(logic [19:0] ppn, logic [6:0] idx, logic [2:0] w);
        return {ppn[15:0], 4'h0, idx, w, 2'b00};
    endfunction

    function automatic logic [255:0] mline(logic [19:0] ppn, logic [6:0] idx);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = mword(ppn, idx, 3'(w));
        return l;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] va, input logic [19:0] ppn, input logic flt,
                          input int lat, input logic xhit, input logic xerr);
        bit got = 0, saw = 0;
        int mc = 0, k_at = -1;
        logic g_hit = 0, g_err = 0;
        logic [31:0] g_data = '0;
        @(negedge clk);
        chk(req_ready, "R11", "ready in idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_waddr = va[31:2];
        @(negedge clk);
        req_valid = 1'b0;
        chk(tlb_req && tlb_vpn == va[31:12], "R2", "vpn issued", 64'(tlb_vpn), 64'(va[31:12]));
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(tlb_req && tlb_vpn == va[31:12] && !rsp_valid && !mem_req, "R2", "stall hold",
                64'({tlb_req, rsp_valid, mem_req}), 64'b100);
        end
        tlb_rsp_valid = 1'b1;
        tlb_ppn = ppn;
        tlb_fault = flt;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            tlb_rsp_valid = 1'b0;
            tlb_fault = 1'b0;
            mem_rsp_valid = 1'b0;
            if (rsp_valid) begin
                got = 1; k_at = k;
                g_hit = rsp_hit; g_err = rsp_err; g_data = rsp_data;
                break;
            end
            if (mem_req) begin
                if (!saw)
                    chk(mem_paddr == {ppn, va[11:5], 5'b0}, "R1", "refill address",
                        64'(mem_paddr), 64'({ppn, va[11:5], 5'b0}));
                saw = 1;
                mc++;
                if (mc == 3) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_line = mline(ppn, va[11:5]);
                end
            end
        end
        chk(got, "R11", "response seen", 64'(got), 64'd1);
        chk(g_hit == xhit, "R3 R6 R7 R8 R10", "hit flag", 64'(g_hit), 64'(xhit));
        chk(g_err == xerr, "R4", "error flag", 64'(g_err), 64'(xerr));
        chk(saw == (!xhit && !xerr), "R4 R5", "refill issued", 64'(saw), 64'(!xhit && !xerr));
        if (!xerr)
            chk(g_data == mword(ppn, va[11:5], va[4:2]), "R5", "data word",
                64'(g_data), 64'(mword(ppn, va[11:5], va[4:2])));
        // R11: hit/fault answer one cycle after translation, fill after 3 waits + 1
        chk(k_at == ((xhit || xerr) ? 0 : 3), "R11", "response cycle", 64'(k_at),
            64'((xhit || xerr) ? 0 : 3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(req_ready && !tlb_req && !mem_req && !rsp_valid, "R9", "reset outputs",
            64'({req_ready, tlb_req, mem_req, rsp_valid}), 64'b1000);

        for (int v = 0; v < NV; v++)
            access(TBL[v].va, TBL[v].ppn, TBL[v].flt, int'(TBL[v].lat),
                   TBL[v].xhit, TBL[v].xerr);

        // R9: reset drops all lines; a formerly resident line misses again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_ready && !rsp_valid, "R9", "ready after reset", 64'(req_ready), 64'd1);
        access(32'h0001_2040, 20'h00080, 1'b0, 0, 1'b0, 1'b0);
        access(32'h0001_2040, 20'h00080, 1'b0, 0, 1'b1, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule